// File: doc/BRIEF.md
# Four-Stage Instruction Pipeline with Decode-Time Address-Register Writes

This block is a cycle-accurate model of a four-slot instruction pipeline. Its stages are fetch, decode, operand fetch and execute. It runs a tiny instruction set over a file of eight 16-bit address registers, a 3-bit register pointer and a global-map register. One instruction word may enter per clock. Every unstalled edge moves each instruction one slot further, so up to four instructions overlap.

Pointer and register writes are made while an instruction sits in decode. The normalize instruction instead reads the pointed-to register and moves the pointer while it sits in execute. Global-map writes are also made at execute, and each instruction takes its map value as it leaves operand fetch. The block has no interlocks, so the hazards these timings cause show up at the ports exactly as they happen.

The trace outputs show, for each slot, the sequence number of the instruction it holds and whether the slot is occupied. A surrounding model or bench uses them to follow the overlap and to see when each write becomes visible.

Top module: `ptc_pipe`

## Requirements
- R1: After reset, all slots are empty, all trace numbers are zero, all registers, the pointer, the map and the execute-slot map are zero, and the sequence counter is zero. A word is accepted on an edge where `in_valid` is high and `stall` is low. It enters the fetch slot tagged with the counter value, and the counter then increments modulo 2^PC_W.
- R2: On every edge with `stall` low, the contents move fetch→decode→operand→execute. Trace slot s (0 fetch, 1 decode, 2 operand, 3 execute) sits at `trace_pc[s*PC_W +: PC_W]` and `trace_vld[s]`. An edge with `in_valid` low puts an empty slot with number 0 into fetch.
- R3: Encoding, by bits 15:12: 0x1 sets the pointer to bits 2:0. 0x2 loads register bits 10:8 with the zero-extended byte in bits 7:0, and bit 11 is ignored. Exactly 0x3000 is normalize. 0x4 writes bits 11:0 to the map. Every other word, including 0x3001 and 0x5xxx, changes nothing.
- R4: A set-pointer or load-register write is applied on the edge that moves the instruction out of decode. It shows on `ar_ptr` and `areg_all` from the next cycle on. Register i sits at `areg_all[i*16 +: 16]`.
- R5: Normalize, on the edge that moves it out of execute, adds one (mod 2^16) to the register selected by the pointer and advances the pointer by one modulo 8.
- R6: When a decode-slot write and an executing normalize share an edge, the decode write is applied first. The normalize then uses the updated pointer and register value, and its pointer update is the one that remains.
- R7: A map write takes effect on the edge that moves it out of execute. `ex_map` shows the map value that the execute-slot instruction captured on the edge it left operand fetch. The next instruction therefore still shows the old map, and the one after it shows the new map.
- R8: While `stall` is high, no slot, trace, register, pointer, map, `ex_map` or counter changes, and input words are not accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction word present |
| in_word | input | 16 | Instruction word |
| stall | input | 1 | Freeze the whole pipeline |
| trace_pc | output | 4*PC_W | Sequence number per slot, fetch in the low field |
| trace_vld | output | 4 | Slot occupied, bit 0 fetch |
| ex_map | output | GM_W | Map value held by the execute-slot instruction |
| areg_all | output | 8*AR_W | Address registers, register 0 in the low field |
| ar_ptr | output | 3 | Register pointer |
| gmap | output | GM_W | Global-map register |

## Verification
A word accepted on edge k is in fetch after edge k and reaches execute after edge k+3. Its decode-stage write is visible after edge k+2. Its normalize or map effect is visible after edge k+4. The bench drives inputs on the falling edge and samples one time unit after each rising edge. It advances a reference model by one edge per step, so every output is compared in the cycle its result is due. Directed sequences pin the hazard cases (normalize with a decode write on the same edge, map lag, stall freeze, non-opcodes) to hand-computed values. A long pseudo-random sweep covers the rest, including counter wrap.

// File: rtl/ptc_pkg.sv
// Package: opcode kinds and the word decoder shared by the pipeline blocks.
// Assumes 16-bit words with the opcode in bits 15:12.
package ptc_pkg;

    typedef enum logic [2:0] {
        K_NOP  = 3'd0,
        K_SETP = 3'd1,
        K_LDAR = 3'd2,
        K_NORM = 3'd3,
        K_GMAP = 3'd4
    } op_kind_e;

    typedef struct packed {
        op_kind_e    kind;
        logic [2:0]  sel;
        logic [7:0]  imm8;
        logic [11:0] imm12;
    } op_dec_t;

    // Split a word into kind and immediate fields; unknown words become no-ops.
    function automatic op_dec_t op_decode(input logic [15:0] w);
        op_dec_t r;
        r.kind  = K_NOP;
        r.sel   = w[10:8];
        r.imm8  = w[7:0];
        r.imm12 = w[11:0];
        case (w[15:12])
            4'h1: begin r.kind = K_SETP; r.sel = w[2:0]; end
            4'h2: r.kind = K_LDAR;
            4'h3: if (w == 16'h3000) r.kind = K_NORM;
            4'h4: r.kind = K_GMAP;
            default: r.kind = K_NOP;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ptc_stage_regs.sv
// Module: ptc_stage_regs
// Shift chain of N instruction slots (valid, sequence number, word).
// Slot 0 loads the input; slot g loads slot g-1. Nothing moves unless adv is high.
// Assumes an empty slot carries number 0 and word 0.
module ptc_stage_regs #(
    parameter int PC_W = 8,
    parameter int W_W  = 16,
    parameter int N    = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              in_vld,
    input  logic [PC_W-1:0]   in_pc,
    input  logic [W_W-1:0]    in_word,
    output logic [N-1:0]      vld,
    output logic [N*PC_W-1:0] pc_flat,
    output logic [N*W_W-1:0]  word_flat
);
    logic [PC_W-1:0] pc_q   [N];
    logic [W_W-1:0]  word_q [N];
    logic [N-1:0]    vld_q;

    for (genvar g = 0; g < N; g++) begin : g_slot
        if (g == 0) begin : g_head
            // Head slot: capture the incoming word or a bubble.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[0]  <= 1'b0;
                    pc_q[0]   <= '0;
                    word_q[0] <= '0;
                end else if (adv) begin
                    vld_q[0]  <= in_vld;
                    pc_q[0]   <= in_vld ? in_pc : '0;
                    word_q[0] <= in_vld ? in_word : '0;
                end
            end
        end else begin : g_tail
            // Later slot: take over the contents of the slot ahead.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    vld_q[g]  <= 1'b0;
                    pc_q[g]   <= '0;
                    word_q[g] <= '0;
                end else if (adv) begin
                    vld_q[g]  <= vld_q[g-1];
                    pc_q[g]   <= pc_q[g-1];
                    word_q[g] <= word_q[g-1];
                end
            end
        end
        assign pc_flat[g*PC_W +: PC_W]  = pc_q[g];
        assign word_flat[g*W_W +: W_W]  = word_q[g];
    end

    assign vld = vld_q;

    // R8: a frozen chain keeps its occupancy.
    a_r8_slots_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(vld_q));

endmodule

// File: rtl/ptc_arch_state.sv
// Module: ptc_arch_state
// Address registers, pointer and global map. Applies the decode-slot write
// first, then the execute-slot normalize on top of it, then a map write.
// Assumes PTR_W is at most 3 (the pointer field of the encoding).
module ptc_arch_state
    import ptc_pkg::*;
#(
    parameter int PTR_W = 3,
    parameter int AR_W  = 16,
    parameter int GM_W  = 12,
    localparam int NAR  = 1 << PTR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              adv,
    input  logic              dec_vld,
    input  logic [15:0]       dec_word,
    input  logic              ex_vld,
    input  logic [15:0]       ex_word,
    output logic [NAR*AR_W-1:0] areg_flat,
    output logic [PTR_W-1:0]  ptr,
    output logic [GM_W-1:0]   gmap
);
    logic [AR_W-1:0]  ar_q [NAR];
    logic [AR_W-1:0]  ar_n [NAR];
    logic [PTR_W-1:0] ptr_q, ptr_n;
    logic [GM_W-1:0]  gm_q, gm_n;
    op_dec_t          d_dec, x_dec;
    logic             dec_setp, ex_norm, ex_gmap;

    assign d_dec    = op_decode(dec_word);
    assign x_dec    = op_decode(ex_word);
    assign dec_setp = dec_vld && (d_dec.kind == K_SETP);
    assign ex_norm  = ex_vld && (x_dec.kind == K_NORM);
    assign ex_gmap  = ex_vld && (x_dec.kind == K_GMAP);

    // Next state: decode write, then normalize on the updated values, then map.
    always_comb begin
        ar_n  = ar_q;
        ptr_n = ptr_q;
        gm_n  = gm_q;
        if (dec_setp)
            ptr_n = d_dec.sel[PTR_W-1:0];
        if (dec_vld && d_dec.kind == K_LDAR)
            ar_n[d_dec.sel[PTR_W-1:0]] = AR_W'(d_dec.imm8);
        if (ex_norm) begin
            ar_n[ptr_n] = ar_n[ptr_n] + AR_W'(1);
            ptr_n       = ptr_n + PTR_W'(1);
        end
        if (ex_gmap)
            gm_n = GM_W'(x_dec.imm12);
    end

    // State registers: commit only on an advancing edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NAR; i++) ar_q[i] <= '0;
            ptr_q <= '0;
            gm_q  <= '0;
        end else if (adv) begin
            for (int i = 0; i < NAR; i++) ar_q[i] <= ar_n[i];
            ptr_q <= ptr_n;
            gm_q  <= gm_n;
        end
    end

    for (genvar i = 0; i < NAR; i++) begin : g_flat
        assign areg_flat[i*AR_W +: AR_W] = ar_q[i];
    end
    assign ptr  = ptr_q;
    assign gmap = gm_q;

    // R8: stall freezes pointer and map.
    a_r8_state_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(ptr_q) && $stable(gm_q)));
    // R5: a normalize without a same-edge pointer set steps the pointer.
    a_r5_norm_step: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ex_norm && !dec_setp) |=> (ptr_q == $past(ptr_q) + PTR_W'(1)));
    // R6: a same-edge pointer set is followed by the normalize step.
    a_r6_set_then_norm: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && ex_norm && dec_setp) |=> (ptr_q == $past(d_dec.sel[PTR_W-1:0]) + PTR_W'(1)));
    // R7: the map moves only under an executing map write.
    a_r7_map_only_exec: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !ex_gmap) |=> $stable(gm_q));

endmodule

// File: rtl/ptc_pipe.sv
// Module: ptc_pipe (top)
// Four-slot pipeline: fetch, decode, operand, execute. Tags accepted words with
// a sequence counter, runs decode writes and execute effects through
// ptc_arch_state, and latches the map each instruction sees as it enters execute.
// Assumes no interlocks; stall freezes everything.
module ptc_pipe
    import ptc_pkg::*;
#(
    parameter int PC_W  = 8,
    parameter int AR_W  = 16,
    parameter int PTR_W = 3,
    parameter int GM_W  = 12,
    localparam int NST  = 4,
    localparam int NAR  = 1 << PTR_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [15:0]         in_word,
    input  logic                stall,
    output logic [NST*PC_W-1:0] trace_pc,
    output logic [NST-1:0]      trace_vld,
    output logic [GM_W-1:0]     ex_map,
    output logic [NAR*AR_W-1:0] areg_all,
    output logic [PTR_W-1:0]    ar_ptr,
    output logic [GM_W-1:0]     gmap
);
    localparam int S_DEC = 1;
    localparam int S_EX  = 3;

    logic                adv;
    logic                accept;
    logic [PC_W-1:0]     pc_cnt;
    logic [NST*16-1:0]   words;
    logic [GM_W-1:0]     ex_map_q;

    assign adv    = !stall;
    assign accept = adv && in_valid;

    // Sequence counter: one step per accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n)      pc_cnt <= '0;
        else if (accept) pc_cnt <= pc_cnt + PC_W'(1);
    end

    ptc_stage_regs #(.PC_W(PC_W), .W_W(16), .N(NST)) u_slots (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .in_vld    (in_valid),
        .in_pc     (pc_cnt),
        .in_word   (in_word),
        .vld       (trace_vld),
        .pc_flat   (trace_pc),
        .word_flat (words)
    );

    ptc_arch_state #(.PTR_W(PTR_W), .AR_W(AR_W), .GM_W(GM_W)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .dec_vld   (trace_vld[S_DEC]),
        .dec_word  (words[S_DEC*16 +: 16]),
        .ex_vld    (trace_vld[S_EX]),
        .ex_word   (words[S_EX*16 +: 16]),
        .areg_flat (areg_all),
        .ptr       (ar_ptr),
        .gmap      (gmap)
    );

    // Map capture: the instruction leaving operand fetch takes the current map.
    always_ff @(posedge clk) begin
        if (!rst_n)   ex_map_q <= '0;
        else if (adv) ex_map_q <= gmap;
    end
    assign ex_map = ex_map_q;

    // R1: an accepted word lands in the fetch slot with the old counter value.
    a_r1_accept: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (trace_vld[0] && trace_pc[PC_W-1:0] == $past(pc_cnt)));
    // R2: occupancy moves one slot per advancing edge.
    a_r2_shift: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (trace_vld[NST-1:1] == $past(trace_vld[NST-2:0])));
    // R7: the execute-slot map equals the map before the entering edge.
    a_r7_map_lag: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (ex_map == $past(gmap)));
    // R8: stall keeps counter and trace.
    a_r8_trace_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(pc_cnt) && $stable(trace_pc)));

endmodule

// File: tb/ptc_pipe_test.sv
// Bench for ptc_pipe: directed hazard cases plus a reference-model sweep.
module ptc_pipe_test;
    localparam int CLK_PERIOD = 10;
    localparam int PC_W = 8;
    localparam int AR_W = 16;
    localparam int GM_W = 12;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [15:0] in_word = '0;
    logic        stall = 1'b0;
    logic [4*PC_W-1:0] trace_pc;
    logic [3:0]        trace_vld;
    logic [GM_W-1:0]   ex_map;
    logic [8*AR_W-1:0] areg_all;
    logic [2:0]        ar_ptr;
    logic [GM_W-1:0]   gmap;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    // reference model state
    logic            m_vld [4];
    logic [PC_W-1:0] m_pc  [4];
    logic [15:0]     m_wd  [4];
    logic [15:0]     m_ar  [8];
    logic [2:0]      m_ptr;
    logic [GM_W-1:0] m_gm, m_exmap;
    logic [PC_W-1:0] m_cnt;

    ptc_pipe uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .stall(stall), .trace_pc(trace_pc), .trace_vld(trace_vld),
        .ex_map(ex_map), .areg_all(areg_all), .ar_ptr(ar_ptr), .gmap(gmap)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_vld[i] = 0; m_pc[i] = 0; m_wd[i] = 0; end
        for (int i = 0; i < 8; i++) m_ar[i] = 0;
        m_ptr = 0; m_gm = 0; m_exmap = 0; m_cnt = 0;
    endtask

    // One advancing or frozen edge of the reference model, built from R1-style rules.
    task automatic model_edge(input logic v, input logic [15:0] w, input logic s);
        logic [2:0] p;
        logic [15:0] dw, xw;
        if (s) return;
        p = m_ptr; dw = m_wd[1]; xw = m_wd[3];
        if (m_vld[1] && dw[15:12] == 4'h1) p = dw[2:0];
        if (m_vld[1] && dw[15:12] == 4'h2) m_ar[dw[10:8]] = {8'h00, dw[7:0]};
        if (m_vld[3] && xw == 16'h3000) begin m_ar[p] = m_ar[p] + 16'd1; p = p + 3'd1; end
        m_ptr = p;
        m_exmap = m_gm;
        if (m_vld[3] && xw[15:12] == 4'h4) m_gm = xw[11:0];
        for (int i = 3; i > 0; i--) begin m_vld[i] = m_vld[i-1]; m_pc[i] = m_pc[i-1]; m_wd[i] = m_wd[i-1]; end
        m_vld[0] = v; m_pc[0] = v ? m_cnt : '0; m_wd[0] = v ? w : '0;
        if (v) m_cnt = m_cnt + 1'b1;
    endtask

    task automatic compare_all();
        logic [3:0] ev;
        for (int i = 0; i < 4; i++) ev[i] = m_vld[i];
        chk("R2", "trace_vld", {28'd0, trace_vld}, {28'd0, ev});
        for (int i = 0; i < 4; i++)
            chk("R1", "trace_pc", {24'd0, trace_pc[i*PC_W +: PC_W]}, {24'd0, m_pc[i]});
        chk("R5", "ar_ptr", {29'd0, ar_ptr}, {29'd0, m_ptr});
        for (int i = 0; i < 8; i++)
            chk("R4", "areg", {16'd0, areg_all[i*16 +: 16]}, {16'd0, m_ar[i]});
        chk("R7", "gmap", {20'd0, gmap}, {20'd0, m_gm});
        chk("R7", "ex_map", {20'd0, ex_map}, {20'd0, m_exmap});
    endtask

    task automatic step(input logic v, input logic [15:0] w, input logic s);
        @(negedge clk);
        in_valid = v; in_word = w; stall = s;
        @(posedge clk);
        model_edge(v, w, s);
        #1;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        logic [15:0] lf;
        logic [15:0] w;
        model_reset();
        repeat (3) @(posedge clk);
        #1;
        // R1 reset state
        chk("R1", "reset vld", {28'd0, trace_vld}, 32'd0);
        chk("R1", "reset ptr", {29'd0, ar_ptr}, 32'd0);
        chk("R1", "reset areg", areg_all[31:0], 32'd0);
        chk("R1", "reset gmap", {20'd0, gmap}, 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // Directed: normalize hazard
        step(1, 16'h1002, 0); compare_all();
        step(1, 16'h2210, 0); compare_all();
        chk("R4", "ptr before decode edge", {29'd0, ar_ptr}, 32'd0);
        step(1, 16'h3000, 0); compare_all();
        chk("R4", "ptr after decode edge", {29'd0, ar_ptr}, 32'd2);
        step(1, 16'h1005, 0); compare_all();
        chk("R4", "r2 loaded", {16'd0, areg_all[2*16 +: 16]}, 32'h10);
        chk("R2", "overlap pcs", trace_pc, 32'h00010203);
        chk("R2", "all slots busy", {28'd0, trace_vld}, 32'hF);
        step(1, 16'h2503, 0); compare_all();
        step(1, 16'h0000, 0); compare_all();
        chk("R6", "ptr set by next word", {29'd0, ar_ptr}, 32'd5);
        step(1, 16'h0000, 0); compare_all();
        chk("R6", "norm ptr", {29'd0, ar_ptr}, 32'd6);
        chk("R6", "norm used loaded r5", {16'd0, areg_all[5*16 +: 16]}, 32'd4);
        chk("R5", "r2 untouched", {16'd0, areg_all[2*16 +: 16]}, 32'h10);

        // R8 stall with a word offered
        step(1, 16'h1007, 1); compare_all();
        chk("R8", "stall pcs", trace_pc, 32'h03040506);
        chk("R8", "stall ptr", {29'd0, ar_ptr}, 32'd6);

        // R7 map lag, R3 non-opcodes
        step(1, 16'h4ABC, 0); compare_all();
        step(1, 16'h3001, 0); compare_all();
        step(1, 16'h5FFF, 0); compare_all();
        step(1, 16'h0000, 0); compare_all();
        chk("R7", "map before exec", {20'd0, gmap}, 32'd0);
        step(1, 16'h0000, 0); compare_all();
        chk("R7", "map after exec", {20'd0, gmap}, 32'hABC);
        chk("R7", "next instr pc", {24'd0, trace_pc[3*PC_W +: PC_W]}, 32'd8);
        chk("R7", "next instr old map", {20'd0, ex_map}, 32'd0);
        step(1, 16'h0000, 0); compare_all();
        chk("R7", "second instr new map", {20'd0, ex_map}, 32'hABC);
        step(0, 16'h1234, 0); compare_all();
        chk("R3", "non-opcodes left ptr", {29'd0, ar_ptr}, 32'd6);
        chk("R2", "bubble in fetch", {31'd0, trace_vld[0]}, 32'd0);
        chk("R3", "ldar bit11 ignored prep", {16'd0, areg_all[1*16 +: 16]}, 32'd0);
        step(1, 16'h29AA, 0); step(1, 0, 0); step(1, 0, 0); compare_all();
        chk("R3", "ldar bit11 ignored", {16'd0, areg_all[1*16 +: 16]}, 32'hAA);

        // Sweep against the reference model
        lf = 16'hACE1;
        for (int n = 0; n < 4000; n++) begin
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            case (lf[2:0])
                3'd0: w = 16'h0000;
                3'd1: w = {4'h1, 9'd0, lf[5:3]};
                3'd2: w = {4'h2, lf[15:4]};
                3'd3: w = lf[6] ? 16'h3001 : 16'h3000;
                3'd4: w = {4'h4, lf[15:4]};
                3'd5: w = 16'h3000;
                default: w = {4'h5 + {1'b0, lf[5:3]}, lf[11:0]};
            endcase
            step(lf[9:8] != 2'b00, w, lf[12:10] == 3'b000);
            compare_all();
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule